// File: doc/BRIEF.md
# Dual-Protocol Parallel Register Host Interface

This block is the slave side of an 8-bit parallel processor bus. It gives an external host read and write access to a bank of 22 byte-wide registers. Twenty of them are general configuration and control storage. One collects alarm events, and one masks those alarms onto an interrupt line. Two static strap inputs select the bus flavour. `proto_6800` picks a 6800-style bus, which uses chip select, a data strobe and a read/write line, or an 8080-style bus, which uses chip select and separate read and write strobes. `bus_muxed` picks either a separate 5-bit address bus or an address carried on the data lines and captured by an address-latch strobe.

Each access runs through one wait-state counter. The counter drives a single handshake pin. It reads as an active-low acknowledge on the 6800 bus and as an active-high ready on the 8080 bus. The read data are captured, and writes take effect, on the clock edge where the wait count expires. A read of the alarm register clears it on that same edge. The data bus is modelled as separate input and output vectors with an output-enable pin. The output enable stands for the tri-state control of the shared pins.

Top module: `hostbus_regif`

## Requirements
- R1: After reset `hs` is 1, `int_n` is 1 and `bus_oe` is 0, and every implemented register reads 0x00.
- R2: With `proto_6800`=1, an access is a strobe with `cs_n`=0 and `ds_n`=0, where `rw`=1 means read and `rw`=0 means write. `hs` stays 1 for the two clock edges after the strobe is first sampled and goes 0 after the third edge. A read then returns the last value written to that address.
- R3: With `proto_6800`=0, a read is `cs_n`=0 with `rd_n`=0, and a write is `cs_n`=0 with `wr_n`=0. `hs` drops to 0 as soon as the strobe is present and returns to 1 after the third sampling edge. Data is valid at that point.
- R4: With `bus_muxed`=1, the address is taken from `bus_din[4:0]` while `ale` is 1 and held after `ale` falls. `bus_din[7:5]` and the `addr` pins are ignored.
- R5: When the strobe or `cs_n` is removed, `hs` returns to 1 in the same cycle. An access aborted before the wait count expires writes nothing.
- R6: `bus_oe` is 1 only while a read strobe is present with `cs_n`=0. It is 0 during writes.
- R7: Addresses 22 to 31 read as 0x00. Writes to them change no register.
- R8: Address 20 is the alarm register. Each bit is set by a 1 on the matching `alarm_in` bit, stays set, and is cleared by a completed read of address 20. Writes to it are ignored. An alarm event on the same edge as the clearing read is not included in that read's data but stays set afterwards.
- R9: Address 21 is an interrupt mask (read/write). `int_n` is 0 exactly when some alarm bit and its mask bit are both 1.
- R10: The strobe pins of the unselected protocol have no effect. In 8080 mode, `ds_n`=0 alone starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| proto_6800 | input | 1 | Strap: 1 = 6800 bus, 0 = 8080 bus |
| bus_muxed | input | 1 | Strap: 1 = multiplexed address/data |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch strobe (multiplexed mode) |
| ds_n | input | 1 | 6800 data strobe, active low |
| rw | input | 1 | 6800 direction, 1 = read |
| rd_n | input | 1 | 8080 read strobe, active low |
| wr_n | input | 1 | 8080 write strobe, active low |
| addr | input | 5 | Address (non-multiplexed mode) |
| bus_din | input | 8 | Data (and multiplexed address) from the host |
| bus_dout | output | 8 | Read data to the host |
| bus_oe | output | 1 | Drive enable for the data pins |
| hs | output | 1 | Handshake: 6800 acknowledge (low) or 8080 ready (high) |
| alarm_in | input | 8 | Alarm event inputs |
| int_n | output | 1 | Interrupt, active low |

## Verification
Two things can land on the same clock edge: a new alarm event, and the completion of a host read of the alarm register that clears it. The bench drives an `alarm_in` pulse timed to meet the edge where the read's wait count expires. It then expects the read data to hold only the older alarm bits. A second read must show the new bit still set, and a third must show the register empty.

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int NREG     = 22,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          proto_6800,
  input  logic          bus_muxed,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          ds_n,
  input  logic          rw,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          hs,
  input  logic [DW-1:0] alarm_in,
  output logic          int_n
);
  localparam int ALARM_ADDR = NREG - 2;
  localparam int MASK_ADDR  = NREG - 1;
  localparam int NRW        = NREG - 2;
  localparam int CW         = $clog2(WAIT_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] alat, eaddr;
  logic [DW-1:0] regs [NRW];
  logic [DW-1:0] alarm_q, mask_q, rd_q, rd_val;
  logic          rd_req, wr_req, strobe, commit, rd_commit, wr_commit, clr_alarm;

  assign rd_req    = !cs_n && (proto_6800 ? (!ds_n && rw) : !rd_n);
  assign wr_req    = !cs_n && (proto_6800 ? (!ds_n && !rw) : (!wr_n && rd_n));
  assign strobe    = rd_req || wr_req;
  assign eaddr     = bus_muxed ? alat : addr;
  assign commit    = (st == S_WAIT) && strobe && (cnt == CW'(WAIT_CYC - 1));
  assign rd_commit = commit && rd_req;
  assign wr_commit = commit && wr_req;
  assign clr_alarm = rd_commit && (int'(eaddr) == ALARM_ADDR);

  assign hs       = proto_6800 ? !((st == S_DONE) && strobe) : !(strobe && st != S_DONE);
  assign bus_oe   = rd_req;
  assign bus_dout = rd_q;
  assign int_n    = ~|(alarm_q & mask_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) alat <= '0;
    else if (ale) alat <= bus_din[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (strobe) begin st <= S_WAIT; cnt <= '0; end
        S_WAIT: if (!strobe) st <= S_IDLE;
                else if (commit) st <= S_DONE;
                else cnt <= cnt + 1'b1;
        default: if (!strobe) st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    if (int'(eaddr) == ALARM_ADDR)     rd_val = alarm_q;
    else if (int'(eaddr) == MASK_ADDR) rd_val = mask_q;
    else if (int'(eaddr) < NRW)        rd_val = regs[eaddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NRW; i++) regs[i] <= '0;
      mask_q  <= '0;
      alarm_q <= '0;
      rd_q    <= '0;
    end else begin
      if (wr_commit && int'(eaddr) < NRW) regs[eaddr] <= bus_din;
      if (wr_commit && int'(eaddr) == MASK_ADDR) mask_q <= bus_din;
      if (rd_commit) rd_q <= rd_val;
      alarm_q <= (clr_alarm ? '0 : alarm_q) | alarm_in;
    end
  end

  AST_ACK_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_6800 && !hs) |-> strobe); // R2
  AST_RDY_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!proto_6800 && $rose(strobe)) |-> !hs); // R3
  AST_ALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(alat)); // R4
  AST_IDLE_HS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> hs); // R5
  AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !cs_n); // R6
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_commit && int'(eaddr) >= NREG) |=> (bus_dout == '0)); // R7
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_alarm |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q))); // R8
  AST_INT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> int_n); // R9
endmodule

// File: tb/tb_hostbus_regif.sv
module tb_hostbus_regif;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic proto_6800 = 1, bus_muxed = 0;
  logic cs_n = 1, ale = 0, ds_n = 1, rw = 1, rd_n = 1, wr_n = 1;
  logic [4:0] addr = '0;
  logic [7:0] bus_din = '0, alarm_in = '0;
  logic [7:0] bus_dout;
  logic bus_oe, hs, int_n;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  hostbus_regif dut (.clk, .rst_n, .proto_6800, .bus_muxed, .cs_n, .ale, .ds_n, .rw,
                     .rd_n, .wr_n, .addr, .bus_din, .bus_dout, .bus_oe, .hs,
                     .alarm_in, .int_n);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit rd, input logic [4:0] a, input logic [7:0] wd,
                     input logic [7:0] alm, output logic [7:0] rdata,
                     output int lat, output logic oe_seen);
    bit done = 0;
    @(negedge clk);
    if (bus_muxed) begin
      ale = 1; bus_din = {3'b101, a}; addr = ~a;
      @(negedge clk);
      ale = 0;
    end else addr = a;
    bus_din = rd ? 8'h3C : wd;
    cs_n = 0;
    if (proto_6800) begin rw = rd; ds_n = 0; end
    else begin rd_n = !rd; wr_n = rd; end
    lat = 0; oe_seen = 0;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
      if (lat == 1) oe_seen = bus_oe;
      if (lat == 2) alarm_in = alm;
      if (lat == 3) alarm_in = '0;
      done = proto_6800 ? (hs == 0) : (hs == 1 && lat > 1);
    end
    rdata = bus_dout;
    cs_n = 1; ds_n = 1; rd_n = 1; wr_n = 1; rw = 1; alarm_in = '0;
    #1 chk("R5 hs idle after strobe off", hs, 1);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string req);
    logic [7:0] r; int l; logic oe;
    acc(0, a, d, 8'h00, r, l, oe);
    chk({req, " write latency"}, l, 3);
    chk("R6 oe low on write", oe, 0);
  endtask

  task automatic rdchk(input logic [4:0] a, input logic [7:0] exp, input string req);
    logic [7:0] r; int l; logic oe;
    acc(1, a, 8'h00, 8'h00, r, l, oe);
    chk({req, " read data"}, r, exp);
    chk({req, " read latency"}, l, 3);
    chk("R6 oe high on read", oe, 1);
  endtask

  task automatic t_reset;
    chk("R1 hs", hs, 1);
    chk("R1 int_n", int_n, 1);
    chk("R1 bus_oe", bus_oe, 0);
    rdchk(5'd0, 8'h00, "R1 reg0");
    rdchk(5'd21, 8'h00, "R1 mask");
  endtask

  task automatic t_6800;
    proto_6800 = 1; bus_muxed = 0;
    wr(5'd5, 8'h5A, "R2");
    rdchk(5'd5, 8'h5A, "R2");
    wr(5'd19, 8'hC3, "R2");
    rdchk(5'd19, 8'hC3, "R2");
  endtask

  task automatic t_8080;
    proto_6800 = 0; bus_muxed = 0;
    @(negedge clk);
    cs_n = 0; #1;
    chk("R3 hs high before strobe", hs, 1);
    rd_n = 0; #1;
    chk("R3 rdy drops with strobe", hs, 0);
    rd_n = 1; cs_n = 1;
    @(negedge clk);
    addr = 5'd5; cs_n = 0; ds_n = 0; rw = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R10 ds_n ignored hs", hs, 1);
    chk("R10 ds_n ignored oe", bus_oe, 0);
    cs_n = 1; ds_n = 1;
    wr(5'd7, 8'h81, "R3");
    rdchk(5'd7, 8'h81, "R3");
    rdchk(5'd5, 8'h5A, "R3 cross-protocol");
  endtask

  task automatic t_mux;
    bus_muxed = 1;
    proto_6800 = 0;
    wr(5'd9, 8'h66, "R4 8080 mux");
    proto_6800 = 1;
    rdchk(5'd9, 8'h66, "R4 6800 mux");
    wr(5'd10, 8'h99, "R4 6800 mux");
    bus_muxed = 0;
    rdchk(5'd10, 8'h99, "R10 direct after mux");
    rdchk(5'd9, 8'h66, "R10 direct after mux");
  endtask

  task automatic t_abort;
    proto_6800 = 1; bus_muxed = 0;
    @(negedge clk);
    addr = 5'd3; bus_din = 8'hEE; cs_n = 0; rw = 0; ds_n = 0;
    @(negedge clk);
    cs_n = 1; #1;
    chk("R5 hs after cs removed", hs, 1);
    @(negedge clk); @(negedge clk);
    ds_n = 1; rw = 1;
    rdchk(5'd3, 8'h00, "R5 aborted write");
  endtask

  task automatic t_unimpl;
    wr(5'd22, 8'h77, "R7");
    rdchk(5'd22, 8'h00, "R7 addr22");
    rdchk(5'd6, 8'h00, "R7 no alias");
    wr(5'd31, 8'h12, "R7");
    rdchk(5'd31, 8'h00, "R7 addr31");
    rdchk(5'd21, 8'h00, "R7 mask untouched");
  endtask

  task automatic t_alarm;
    logic [7:0] r; int l; logic oe;
    @(negedge clk); alarm_in = 8'h05;
    @(negedge clk); alarm_in = 8'h00;
    @(negedge clk);
    wr(5'd20, 8'h00, "R8");
    rdchk(5'd20, 8'h05, "R8 sticky");
    rdchk(5'd20, 8'h00, "R8 cleared");
    @(negedge clk); alarm_in = 8'h01;
    @(negedge clk); alarm_in = 8'h00;
    acc(1, 5'd20, 8'h00, 8'h80, r, l, oe);
    chk("R8 concurrent read data", r, 8'h01);
    rdchk(5'd20, 8'h80, "R8 concurrent event kept");
    rdchk(5'd20, 8'h00, "R8 cleared again");
    wr(5'd20, 8'hFF, "R8");
    rdchk(5'd20, 8'h00, "R8 write ignored");
  endtask

  task automatic t_int;
    @(negedge clk); alarm_in = 8'h02;
    @(negedge clk); alarm_in = 8'h00;
    @(negedge clk);
    chk("R9 masked alarm", int_n, 1);
    wr(5'd21, 8'h02, "R9");
    @(negedge clk);
    chk("R9 int asserted", int_n, 0);
    rdchk(5'd21, 8'h02, "R9 mask");
    wr(5'd21, 8'h01, "R9");
    @(negedge clk);
    chk("R9 other bit masked", int_n, 1);
    wr(5'd21, 8'h03, "R9");
    @(negedge clk);
    chk("R9 int again", int_n, 0);
    rdchk(5'd20, 8'h02, "R9 alarm");
    @(negedge clk);
    chk("R9 int released", int_n, 1);
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_6800;
    t_8080;
    t_mux;
    t_abort;
    t_unimpl;
    t_alarm;
    t_int;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule